// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers single-cycle event pulses from a mixed-signal subsystem into a sticky status register. The sources are supply monitors, ADC completion, ADC FIFO and accumulator fill, ADC window alarms, and rising and falling edges on analog and digital I/O channels. A mask register with active-low enables decides which status bits can raise the single interrupt output. Software reads the status register through a register-access front end. That front end tells the block when a status read is recognised, when it completes, and when it is aborted.

While a status read is in flight, the reported status is held still. Events that arrive during the read are parked in a pending register and merged in when the read ends. The interrupt is released as soon as the read is recognised. When the read ends it is asserted again if unmasked status is still there, either because the read was aborted or because a fresh unmasked event arrived during it. A soft-reset command, already decoded from the serial bus by the front end, returns every register to its default.

A two-state read tracker drives the sequencing. In state ST_IDLE, events go straight into status. The transition "start" (rd_start_i) moves the tracker to ST_READ. In ST_READ, events go to the pending register and the interrupt is held low. The transition "done" (rd_done_i) returns it to ST_IDLE: status is replaced by the pending events. The transition "abort" (rd_abort_i) also returns it to ST_IDLE: pending events are ORed into the status that was kept. The transition "soft reset" (soft_rst_i) forces ST_IDLE from either state.

Top module: `irq_status_ctrl`

## Requirements
- R1: When no status read is active, irq_o is 1 exactly when some bit has status 1 and mask 0. A mask bit of 1 blocks its status bit from raising the interrupt.
- R2: After rst_n low, or one cycle after soft_rst_i, all of the following hold: status_o is all zeros, mask_o is all ones, irq_o is 0, pending events are discarded and the tracker is in ST_IDLE.
- R3: Outside a read, an event pulse on evt_i bit k sets status_o bit k at the next clock edge. The bit stays set until a completed read clears it.
- R4: Once irq_o is 1, further unmasked events leave it at 1 with no low cycle.
- R5: rd_start_i in ST_IDLE drives irq_o to 0 from the next edge. irq_o stays 0 while the tracker remains in ST_READ.
- R6: Events on the start cycle and during ST_READ do not change status_o. They are held as pending.
- R7: rd_done_i in ST_READ sets status_o to the pending events ORed with any event in that same cycle. The bits that were reported are cleared.
- R8: rd_abort_i in ST_READ keeps status_o and ORs into it the pending events and any event in that cycle. irq_o asserts again at that edge if any resulting bit is unmasked.
- R9: After a completed read, irq_o asserts again at the ending edge if an unmasked event arrived during the read.
- R10: The bit layout is, from MSB down, in groups of four: bits 23:20 analog rising edges; bits 19:16 digital rising edges; bit 15 first supply monitor, bit 14 second supply monitor, bit 13 third supply monitor, bit 12 ADC done; bits 11:8 analog falling edges; bits 7:4 digital falling edges; bit 3 FIFO full, bit 2 accumulator full, bit 1 above-window alarm, bit 0 below-window alarm. Mask bit k gates status bit k.
- R11: If rd_abort_i and rd_done_i arrive in the same cycle, the abort wins. rd_done_i and rd_abort_i have no effect in ST_IDLE. rd_start_i has no effect in ST_READ.
- R12: mask_we_i loads mask_wdata_i at the next edge in either state. Outside a read, the new mask gates irq_o at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Decoded soft-reset command, one cycle |
| evt_i | input | 24 | Event pulses, one per status bit |
| rd_start_i | input | 1 | Status read recognised |
| rd_done_i | input | 1 | Status read completed |
| rd_abort_i | input | 1 | Status read aborted |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 24 | Mask write data |
| status_o | output | 24 | Sticky status register, read data |
| mask_o | output | 24 | Mask register |
| irq_o | output | 1 | Registered interrupt, active high |

## Verification
The assertions assume only that rst_n is held low before the first clock edge. They place no ordering rule on the read strobes, because the tracker defines what happens for any mix of start, done and abort, including all three at once. The stimulus exploits this freedom. It draws sparse single-bit events, random read strobes in both states, occasional mask writes and rare soft resets, so that done and abort appear in ST_IDLE and start appears in ST_READ. The directed sequences then pin down the named reassertion cases.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_READ = 1'b1
    } rd_state_e;

    typedef struct packed {
        logic defer;      // events go to pending, status frozen
        logic fin_clear;  // completed read: status <= pending | evt
        logic fin_keep;   // aborted read: status |= pending | evt
    } upd_ctl_t;

endpackage

// File: rtl/irq_read_fsm.sv
module irq_read_fsm
    import irq_status_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     soft_rst_i,
    input  logic     rd_start_i,
    input  logic     rd_done_i,
    input  logic     rd_abort_i,
    output upd_ctl_t ctl_o,
    output logic     busy_o,
    output logic     busy_next_o
);

    rd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_start_i) state_d = ST_READ;
            ST_READ: if (rd_abort_i || rd_done_i) state_d = ST_IDLE;
        endcase
        if (soft_rst_i) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        ctl_o = '0;
        unique case (state_q)
            ST_IDLE: begin
                ctl_o.defer = rd_start_i;
            end
            ST_READ: begin
                ctl_o.fin_keep  = rd_abort_i;
                ctl_o.fin_clear = rd_done_i && !rd_abort_i;
                ctl_o.defer     = !rd_done_i && !rd_abort_i;
            end
        endcase
        busy_o      = (state_q == ST_READ);
        busy_next_o = (state_d == ST_READ);
    end

endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
    import irq_status_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst_i,
    input  logic [W-1:0] evt_i,
    input  upd_ctl_t     ctl_i,
    output logic [W-1:0] status_q,
    output logic [W-1:0] status_d,
    output logic [W-1:0] pend_q
);

    logic [W-1:0] pend_d;

    always_comb begin
        status_d = status_q;
        pend_d   = pend_q;
        if (soft_rst_i) begin
            status_d = '0;
            pend_d   = '0;
        end else if (ctl_i.fin_clear) begin
            status_d = pend_q | evt_i;
            pend_d   = '0;
        end else if (ctl_i.fin_keep) begin
            status_d = status_q | pend_q | evt_i;
            pend_d   = '0;
        end else if (ctl_i.defer) begin
            pend_d   = pend_q | evt_i;
        end else begin
            status_d = status_q | evt_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            pend_q   <= '0;
        end else begin
            status_q <= status_d;
            pend_q   <= pend_d;
        end
    end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst_i,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] mask_d
);

    localparam logic [W-1:0] MASK_DEFAULT = '1;

    always_comb begin
        mask_d = mask_q;
        if (soft_rst_i)  mask_d = MASK_DEFAULT;
        else if (we_i)   mask_d = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= MASK_DEFAULT;
        else        mask_q <= mask_d;
    end

endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen #(
    parameter int W     = 24,
    parameter int GRP_W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status_d,
    input  logic [W-1:0] mask_d,
    input  logic         hold_low_i,
    output logic         irq_o
);

    localparam int NGRP = W / GRP_W;

    logic [NGRP-1:0] grp_hit;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign grp_hit[g] = |(status_d[g*GRP_W +: GRP_W] & ~mask_d[g*GRP_W +: GRP_W]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= !hold_low_i && (|grp_hit);
    end

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_status_pkg::*;
#(
    parameter int GRP_W  = 4,
    localparam int STAT_W = 6 * GRP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst_i,
    input  logic [STAT_W-1:0] evt_i,
    input  logic              rd_start_i,
    input  logic              rd_done_i,
    input  logic              rd_abort_i,
    input  logic              mask_we_i,
    input  logic [STAT_W-1:0] mask_wdata_i,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] mask_o,
    output logic              irq_o
);

    upd_ctl_t          ctl;
    logic              rd_busy, rd_busy_next;
    logic [STAT_W-1:0] status_next, pend_q, mask_next;

    irq_read_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst_i  (soft_rst_i),
        .rd_start_i  (rd_start_i),
        .rd_done_i   (rd_done_i),
        .rd_abort_i  (rd_abort_i),
        .ctl_o       (ctl),
        .busy_o      (rd_busy),
        .busy_next_o (rd_busy_next)
    );

    irq_status_regs #(.W(STAT_W)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_i (soft_rst_i),
        .evt_i      (evt_i),
        .ctl_i      (ctl),
        .status_q   (status_o),
        .status_d   (status_next),
        .pend_q     (pend_q)
    );

    irq_mask_reg #(.W(STAT_W)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_i (soft_rst_i),
        .we_i       (mask_we_i),
        .wdata_i    (mask_wdata_i),
        .mask_q     (mask_o),
        .mask_d     (mask_next)
    );

    irq_out_gen #(.W(STAT_W), .GRP_W(GRP_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .status_d   (status_next),
        .mask_d     (mask_next),
        .hold_low_i (rd_busy_next),
        .irq_o      (irq_o)
    );

endmodule

module irq_status_ctrl_chk #(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic         soft_rst_i,
    input logic [W-1:0] evt_i,
    input logic         rd_start_i,
    input logic         rd_done_i,
    input logic         rd_abort_i,
    input logic [W-1:0] status_o,
    input logic [W-1:0] mask_o,
    input logic         irq_o,
    input logic         busy,
    input logic [W-1:0] pend
);

    assert_irq_follows_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (irq_o == |(status_o & ~mask_o)));

    assert_soft_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_i |=> (mask_o == '1 && status_o == '0 && !irq_o && !busy));

    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !rd_start_i && !soft_rst_i) |=> ((status_o & $past(status_o)) == $past(status_o)));

    assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !irq_o);

    assert_status_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_done_i && !rd_abort_i && !soft_rst_i) |=> $stable(status_o));

    assert_clear_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_done_i && !rd_abort_i && !soft_rst_i) |=> (status_o == $past(pend | evt_i)));

    assert_abort_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_abort_i && !soft_rst_i) |=> (status_o == $past(status_o | pend | evt_i)));

    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_done_i && !rd_abort_i && !soft_rst_i) |=> busy);

endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.W(STAT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst_i (soft_rst_i),
    .evt_i      (evt_i),
    .rd_start_i (rd_start_i),
    .rd_done_i  (rd_done_i),
    .rd_abort_i (rd_abort_i),
    .status_o   (status_o),
    .mask_o     (mask_o),
    .irq_o      (irq_o),
    .busy       (rd_busy),
    .pend       (pend_q)
);

// File: tb/test_irq_status_ctrl.sv
`timescale 1ns/1ps
module test_irq_status_ctrl;

    localparam int W = 24;
    // bit positions from R10
    localparam int B_MON_A   = 15;
    localparam int B_ADC_DN  = 12;
    localparam int B_DFALL2  = 5;
    localparam int B_FIFO    = 3;
    localparam int B_LT      = 0;
    localparam int B_ARISE4  = 23;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         soft_rst_i = 1'b0;
    logic [W-1:0] evt_i = '0;
    logic         rd_start_i = 1'b0, rd_done_i = 1'b0, rd_abort_i = 1'b0;
    logic         mask_we_i = 1'b0;
    logic [W-1:0] mask_wdata_i = '0;
    logic [W-1:0] status_o, mask_o;
    logic         irq_o;

    int tests = 0, fails = 0;
    bit finished = 0;

    // reference state
    logic [W-1:0] m_st = '0, m_pd = '0, m_mask = '1;
    logic         m_busy = 1'b0, m_irq = 1'b0;

    always #2.5 clk = ~clk;

    irq_status_ctrl i_irq_status_ctrl (
        .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i), .evt_i(evt_i),
        .rd_start_i(rd_start_i), .rd_done_i(rd_done_i), .rd_abort_i(rd_abort_i),
        .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
        .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o)
    );

    function automatic logic exp_irq(logic [W-1:0] st, logic [W-1:0] mk, logic busy);
        return !busy && (|(st & ~mk));
    endfunction

    task automatic model_step();
        logic [W-1:0] st = m_st, pd = m_pd, mk = m_mask;
        logic b = m_busy;
        if (soft_rst_i) begin
            st = '0; pd = '0; mk = '1; b = 1'b0;
        end else begin
            if (mask_we_i) mk = mask_wdata_i;
            if (m_busy) begin
                if (rd_abort_i)     begin st = m_st | m_pd | evt_i; pd = '0; b = 1'b0; end
                else if (rd_done_i) begin st = m_pd | evt_i;        pd = '0; b = 1'b0; end
                else                pd = m_pd | evt_i;
            end else if (rd_start_i) begin
                pd = m_pd | evt_i; b = 1'b1;
            end else begin
                st = m_st | evt_i;
            end
        end
        m_st = st; m_pd = pd; m_mask = mk; m_busy = b;
        m_irq = exp_irq(st, mk, b);
    endtask

    task automatic compare(string tag);
        tests++;
        if (status_o !== m_st || mask_o !== m_mask || irq_o !== m_irq) begin
            fails++;
            $display("FAIL %s: status=%h mask=%h irq=%b expected status=%h mask=%h irq=%b",
                     tag, status_o, mask_o, irq_o, m_st, m_mask, m_irq);
        end
    endtask

    // drive one cycle of inputs (called at negedge), then check after the edge
    task automatic cyc(string tag, logic [W-1:0] e, logic s, logic d, logic a,
                       logic we, logic [W-1:0] md, logic sr);
        evt_i = e; rd_start_i = s; rd_done_i = d; rd_abort_i = a;
        mask_we_i = we; mask_wdata_i = md; soft_rst_i = sr;
        @(posedge clk);
        model_step();
        #1;
        compare(tag);
        @(negedge clk);
        evt_i = '0; rd_start_i = 0; rd_done_i = 0; rd_abort_i = 0;
        mask_we_i = 0; soft_rst_i = 0;
    endtask

    function automatic logic [W-1:0] bitv(int k);
        logic [W-1:0] v = '0;
        v[k] = 1'b1;
        return v;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1729));
        repeat (3) @(negedge clk);
        #1 compare("R2 reset defaults");
        rst_n = 1'b1;
        @(negedge clk);

        // masked event: status sets, no interrupt
        cyc("R3 sticky set, R1 masked no irq", bitv(B_MON_A), 0,0,0, 0,'0, 0);
        cyc("R3 status holds", '0, 0,0,0, 0,'0, 0);
        // unmask ADC done only (R10 bit 12)
        cyc("R12 mask write", '0, 0,0,0, 1, ~bitv(B_ADC_DN), 0);
        cyc("R10 ADC done raises irq", bitv(B_ADC_DN), 0,0,0, 0,'0, 0);
        cyc("R10 neighbour bit masked", bitv(B_FIFO), 0,0,0, 0,'0, 0);
        cyc("R4 irq stays high", bitv(B_ADC_DN), 0,0,0, 0,'0, 0);
        // read with new unmasked event during it
        cyc("R5 irq released on start", '0, 1,0,0, 0,'0, 0);
        cyc("R6 event deferred", bitv(B_ADC_DN), 0,0,0, 0,'0, 0);
        cyc("R11 start in read ignored", '0, 1,0,0, 0,'0, 0);
        cyc("R9 reassert after done", '0, 0,1,0, 0,'0, 0);
        // clean completed read clears
        cyc("R5 start", '0, 1,0,0, 0,'0, 0);
        cyc("R7 clear on done", '0, 0,1,0, 0,'0, 0);
        // aborted read
        cyc("R3 set", bitv(B_ADC_DN) | bitv(B_LT), 0,0,0, 0,'0, 0);
        cyc("R5 start", '0, 1,0,0, 0,'0, 0);
        cyc("R8 reassert after abort", '0, 0,0,1, 0,'0, 0);
        // done/abort in idle ignored
        cyc("R11 done in idle ignored", '0, 0,1,0, 0,'0, 0);
        cyc("R11 abort in idle ignored", '0, 0,0,1, 0,'0, 0);
        // abort wins over done
        cyc("R5 start", bitv(B_ARISE4), 1,0,0, 0,'0, 0);
        cyc("R11 abort beats done", '0, 0,1,1, 0,'0, 0);
        // mask write during read, then finish
        cyc("R5 start", '0, 1,0,0, 0,'0, 0);
        cyc("R12 mask write in read", '0, 0,0,0, 1, ~bitv(B_DFALL2), 0);
        cyc("R7 done with same-cycle event", bitv(B_DFALL2), 0,1,0, 0,'0, 0);
        // soft reset mid-read
        cyc("R5 start", bitv(B_MON_A), 1,0,0, 0,'0, 0);
        cyc("R2 soft reset", '0, 0,0,0, 0,'0, 1);
        cyc("R2 after soft reset", '0, 0,1,0, 0,'0, 0);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic [W-1:0] e = '0;
            logic [W-1:0] md;
            if ($urandom % 3 == 0) e[$urandom % W] = 1'b1;
            md = W'($urandom);
            cyc("R1 random", e,
                ($urandom % 6 == 0), ($urandom % 5 == 0), ($urandom % 12 == 0),
                ($urandom % 25 == 0), md, ($urandom % 400 == 0));
        end
        finish_run();
    end

endmodule